// File: doc/BRIEF.md
# Segment Base/Limit Address Translator

This block turns a segment-relative address into a linear address. It keeps a small bank of segment slots. Each slot holds a base and a limit. Software reloads the slots through a write port whenever the running process changes.

Each request names a slot and carries a 32-bit offset. A push-style request always uses the stack slot, and the selector sent with it is ignored. The offset is compared with the slot's limit. If the offset is below the limit, the slot's base is added to the offset and the result goes out as the linear address. Otherwise the block returns a fault, together with a cause code. The cause code tells a limit overrun apart from a selector that names no slot.

The response is registered. It arrives on the clock cycle after the request. Descriptor fetching, privilege checks and everything after the linear address belong to other blocks.

Top module: `seg_xlate`

## Requirements
- R1: When the offset is strictly less than the selected slot's limit, the response one cycle later has rsp_fault=0, rsp_cause=2'b00 and rsp_addr equal to the slot base plus the offset.
- R2: When the offset is greater than or equal to the selected slot's limit, the response has rsp_fault=1, rsp_cause=2'b01 and rsp_addr=0. An offset exactly equal to the limit faults.
- R3: There are six slots. Slot 0 is code, slot 1 is data, slot 2 is stack, and slots 3 to 5 are general. A request with req_push=0 and req_sel equal to 6 or 7 responds with rsp_fault=1, rsp_cause=2'b10 and rsp_addr=0.
- R4: A request with req_push=1 is translated through slot 2 whatever the value of req_sel, including the values 6 and 7. It never produces cause 2'b10.
- R5: rsp_valid is 1 exactly in the cycle after a cycle with req_valid=1. In every other cycle rsp_valid and rsp_fault are 0.
- R6: A write with wr_en=1 stores wr_data into slot wr_sel. When wr_limit=1 it writes the limit; when wr_limit=0 it writes the base. A write with wr_sel of 6 or 7 changes no slot.
- R7: A write in the same cycle as a request does not affect that request. It applies to requests from the next cycle onward.
- R8: After reset every base and limit is zero. rsp_valid is 0, and any access faults with cause 2'b01 until a limit is programmed.
- R9: The sum of base and offset wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_push | input | 1 | Push-style request: uses the stack slot and ignores req_sel |
| req_sel | input | 3 | Slot selector for the request |
| req_off | input | 32 | Offset within the segment |
| wr_en | input | 1 | Slot register write enable |
| wr_sel | input | 3 | Slot to write |
| wr_limit | input | 1 | 1 writes the limit, 0 writes the base |
| wr_data | input | 32 | Value to write |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | 32 | Linear address; zero on a fault |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 2 | 00 none, 01 limit overrun, 10 illegal selector |

## Verification
The bench probes offsets at the limit minus one, at the limit itself and above it. A design that compares with less-or-equal would accept the boundary offset instead of faulting. Selectors 6 and 7 are sent both with and without the push flag. A design that checks the selector before applying the push override would raise a selector fault on a legal stack push. A write that lands in the same cycle as a read of the same slot catches a write bypass, which would show the new value one request early. Bases near the top of the address range catch an adder that saturates or carries into a wider result instead of wrapping.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SLOT_CODE  = 0;
  localparam int SLOT_DATA  = 1;
  localparam int SLOT_STACK = 2;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_LIMIT    = 2'b01,
    CAUSE_SELECTOR = 2'b10
  } fault_cause_e;
endpackage

// File: rtl/seg_sel_resolve.sv
module seg_sel_resolve #(
  parameter int NSEG       = 6,
  parameter int SEL_W      = 3,
  parameter int STACK_SLOT = 2
) (
  input  logic             push,
  input  logic [SEL_W-1:0] sel,
  output logic [SEL_W-1:0] idx,
  output logic             legal
);
  localparam logic [SEL_W-1:0] LAST_IDX  = SEL_W'(NSEG - 1);
  localparam logic [SEL_W-1:0] STACK_IDX = SEL_W'(STACK_SLOT);

  always_comb begin
    if (push) begin
      idx   = STACK_IDX;
      legal = 1'b1;
    end else begin
      idx   = sel;
      legal = (sel <= LAST_IDX);
    end
  end
endmodule

// File: rtl/seg_bank.sv
module seg_bank #(
  parameter int NSEG  = 6,
  parameter int SEL_W = 3,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_limit,
  input  logic [AW-1:0]    wr_data,
  input  logic [SEL_W-1:0] rd_idx,
  output logic [AW-1:0]    rd_base,
  output logic [AW-1:0]    rd_lim
);
  logic [AW-1:0] base_q [NSEG];
  logic [AW-1:0] lim_q  [NSEG];

  for (genvar s = 0; s < NSEG; s++) begin : g_slot
    localparam logic [SEL_W-1:0] MY_IDX = SEL_W'(s);
    logic hit;
    assign hit = wr_en && (wr_sel == MY_IDX);

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[s] <= '0;
        lim_q[s]  <= '0;
      end else if (hit) begin
        if (wr_limit) lim_q[s]  <= wr_data;
        else          base_q[s] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_base = '0;
    rd_lim  = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (rd_idx == SEL_W'(s)) begin
        rd_base = base_q[s];
        rd_lim  = lim_q[s];
      end
    end
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] off,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] lim,
  input  logic          legal,
  output logic [AW-1:0] lin,
  output logic          fault,
  output fault_cause_e  cause
);
  logic          in_bounds;
  logic [AW-1:0] sum;

  assign in_bounds = (off < lim);
  assign sum       = base + off;

  always_comb begin
    if (!legal) begin
      fault = 1'b1;
      cause = CAUSE_SELECTOR;
      lin   = '0;
    end else if (!in_bounds) begin
      fault = 1'b1;
      cause = CAUSE_LIMIT;
      lin   = '0;
    end else begin
      fault = 1'b0;
      cause = CAUSE_NONE;
      lin   = sum;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NSEG       = 6,
  parameter int STACK_SLOT = SLOT_STACK,
  localparam int SEL_W     = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_push,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [AW-1:0]    req_off,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_limit,
  input  logic [AW-1:0]    wr_data,
  output logic             rsp_valid,
  output logic [AW-1:0]    rsp_addr,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause
);
  logic [SEL_W-1:0] slot_idx;
  logic             slot_legal;
  logic [AW-1:0]    slot_base;
  logic [AW-1:0]    slot_lim;
  logic [AW-1:0]    lin_d;
  logic             fault_d;
  fault_cause_e     cause_d;

  seg_sel_resolve #(
    .NSEG(NSEG), .SEL_W(SEL_W), .STACK_SLOT(STACK_SLOT)
  ) u_resolve (
    .push (req_push),
    .sel  (req_sel),
    .idx  (slot_idx),
    .legal(slot_legal)
  );

  seg_bank #(
    .NSEG(NSEG), .SEL_W(SEL_W), .AW(AW)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_limit(wr_limit),
    .wr_data (wr_data),
    .rd_idx  (slot_idx),
    .rd_base (slot_base),
    .rd_lim  (slot_lim)
  );

  seg_check #(.AW(AW)) u_check (
    .off  (req_off),
    .base (slot_base),
    .lim  (slot_lim),
    .legal(slot_legal),
    .lin  (lin_d),
    .fault(fault_d),
    .cause(cause_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= CAUSE_NONE;
    end else begin
      rsp_valid <= req_valid;
      rsp_addr  <= req_valid ? lin_d : '0;
      rsp_fault <= req_valid && fault_d;
      rsp_cause <= req_valid ? cause_d : CAUSE_NONE;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int AW    = 32,
  parameter int NSEG  = 6,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_push,
  input logic [SEL_W-1:0] req_sel,
  input logic             rsp_valid,
  input logic [AW-1:0]    rsp_addr,
  input logic             rsp_fault,
  input logic [1:0]       rsp_cause
);
  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NSEG - 1);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R5
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_fault)); // R5
  AST_LIMIT_FAULT_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_addr == '0 && rsp_cause != 2'b00)); // R2
  AST_CLEAN_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'b00)); // R1
  AST_BAD_SELECTOR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_push && req_sel > LAST_IDX) |=> (rsp_fault && rsp_cause == 2'b10)); // R3
  AST_PUSH_NO_SEL_FAULT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_push) |=> (rsp_cause != 2'b10)); // R4
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid); // R8
endmodule

bind seg_xlate seg_xlate_chk #(.AW(AW), .NSEG(NSEG), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_push (req_push),
  .req_sel  (req_sel),
  .rsp_valid(rsp_valid),
  .rsp_addr (rsp_addr),
  .rsp_fault(rsp_fault),
  .rsp_cause(rsp_cause)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, req_push = 0, wr_en = 0, wr_limit = 0;
  logic [2:0]  req_sel = 0, wr_sel = 0;
  logic [31:0] req_off = 0, wr_data = 0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_addr;
  logic [1:0]  rsp_cause;

  always #10 clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_push(req_push),
    .req_sel(req_sel), .req_off(req_off), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_limit(wr_limit), .wr_data(wr_data), .rsp_valid(rsp_valid),
    .rsp_addr(rsp_addr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
  );

  logic [31:0] m_base [6];
  logic [31:0] m_lim  [6];
  logic        e_valid = 0, e_fault = 0;
  logic [31:0] e_addr = 0;
  logic [1:0]  e_cause = 0;
  string       e_tag = "R8";
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check_prev();
    logic ok;
    checks++;
    if (e_valid)
      ok = rsp_valid && rsp_fault == e_fault && rsp_cause == e_cause && rsp_addr == e_addr;
    else
      ok = !rsp_valid && !rsp_fault;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got valid=%0b fault=%0b cause=%0d addr=%h expected valid=%0b fault=%0b cause=%0d addr=%h",
               e_tag, rsp_valid, rsp_fault, rsp_cause, rsp_addr, e_valid, e_fault, e_cause, e_addr);
    end
  endtask

  task automatic step(input logic v, input logic p, input logic [2:0] s, input logic [31:0] o,
                      input logic we, input logic [2:0] ws, input logic wl, input logic [31:0] wd,
                      input string tag);
    int slot;
    @(negedge clk);
    check_prev();
    req_valid = v; req_push = p; req_sel = s; req_off = o;
    wr_en = we; wr_sel = ws; wr_limit = wl; wr_data = wd;
    e_valid = v; e_fault = 0; e_cause = 0; e_addr = 0;
    slot = p ? 2 : int'(s);
    if (v) begin
      if (slot > 5) begin
        e_fault = 1; e_cause = 2'b10; e_tag = "R3";
      end else if (o >= m_lim[slot]) begin
        e_fault = 1; e_cause = 2'b01; e_tag = "R2";
      end else begin
        e_addr = m_base[slot] + o; e_tag = p ? "R4" : "R1";
      end
    end else e_tag = "R5";
    if (tag != "") e_tag = tag;
    if (we && ws < 3'd6) begin
      if (wl) m_lim[ws] = wd;
      else    m_base[ws] = wd;
    end
  endtask

  task automatic rd(input logic [2:0] s, input logic [31:0] o, input string tag);
    step(1, 0, s, o, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(input logic [2:0] s, input logic l, input logic [31:0] d);
    step(0, 0, 0, 0, 1, s, l, d, "R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin m_base[i] = 0; m_lim[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R8: reset state, unprogrammed slots fault on limit
    step(0, 0, 0, 0, 0, 0, 0, 0, "R8");
    rd(0, 0, "R8");
    rd(5, 32'h10, "R8");
    step(1, 1, 0, 0, 0, 0, 0, 0, "R8");
    // R6: program slots
    for (int i = 0; i < 6; i++) begin
      wr(3'(i), 0, 32'h1000_0000 * (i + 1));
      wr(3'(i), 1, 32'h100 << i);
    end
    // R1 / R2: limit boundaries
    rd(0, 32'h0, "R1");
    rd(0, 32'hFF, "R1");
    rd(0, 32'h100, "R2");
    rd(1, 32'h201, "R2");
    rd(1, 32'h1FF, "R1");
    // R3: illegal selectors
    rd(6, 32'h0, "R3");
    rd(7, 32'h0, "R3");
    // R4: push ignores selector
    step(1, 1, 7, 32'h3FF, 0, 0, 0, 0, "R4");
    step(1, 1, 0, 32'h400, 0, 0, 0, 0, "R4");
    step(1, 1, 6, 32'h10, 0, 0, 0, 0, "R4");
    // R6: write to slot 6/7 ignored, all slots intact
    wr(6, 1, 32'hFFFF_FFFF);
    wr(7, 0, 32'h1234_5678);
    for (int i = 0; i < 6; i++) rd(3'(i), 32'h80, "R6");
    // R7: write coincident with request
    step(1, 0, 3, 32'h900, 1, 3, 1, 32'h1000, "R7");
    rd(3, 32'h900, "R7");
    step(1, 0, 3, 32'h4, 1, 3, 0, 32'h55, "R7");
    rd(3, 32'h4, "R7");
    // R9: wrap-around
    wr(4, 0, 32'hFFFF_FFF0);
    wr(4, 1, 32'hFFFF_FFFF);
    rd(4, 32'h20, "R9");
    rd(4, 32'hFFFF_FFFE, "R9");
    // R5: idle gaps
    step(0, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 1, 6, 32'h1, 0, 0, 0, 0, "R5");
    // mixed stimulus
    for (int n = 0; n < 600; n++) begin
      logic [2:0]  s  = 3'($urandom_range(0, 7));
      logic [2:0]  ws = 3'($urandom_range(0, 7));
      logic [31:0] o;
      int          sl = (s > 5) ? 0 : int'(s);
      case ($urandom_range(0, 3))
        0: o = m_lim[sl];
        1: o = m_lim[sl] - 1;
        2: o = m_lim[sl] + 1;
        default: o = $urandom;
      endcase
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 4) == 0), s, o,
           1'($urandom_range(0, 3) == 0), ws, 1'($urandom_range(0, 1)),
           ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 4096)) : $urandom, "");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "R5");
    @(negedge clk);
    check_prev();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule